// File: doc/BRIEF.md
# Serial Flash Command and Status Controller

This block is the slave-side command logic of a serial NOR flash device. It watches the SPI pins from a fast system clock, shifts in opcode bytes on rising SCK edges in either mode 0 or mode 3, and acts on a completed frame only when chip-select returns high. It keeps one status byte that holds a busy flag, a write-enable latch, four protection bits and an auto-increment flag. Software reads this byte back over MISO.

A chip erase is accepted only when the write-enable latch is set and no protection bit is set. An accepted erase drives a one-cycle strobe to the external array, which fills every byte with 0xFF. The block then holds BUSY high for a programmable number of system clocks to stand in for the self-timed erase. The status register can be written only straight after an arming frame. Status reads stream the register for as long as the host keeps clocking.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset the status byte reads 0x00, the MISO output enable is low and no erase strobe has been issued. Status layout: bit 0 BUSY, bit 1 write-enable latch, bits 5:2 protection, bit 6 auto-increment, bit 7 always 0.
- R2: A frame holding exactly the byte 0x06 sets the write-enable latch when chip-select rises.
- R3: Command frames take effect only when they have exactly 8 SCK rising edges (16 for a status write). Frames of any other length leave the status unchanged.
- R4: Opcode 0x04 clears the write-enable latch and the auto-increment bit and leaves the protection bits unchanged.
- R5: A 16-bit frame of 0x01 followed by a data byte loads status bits 6:2 from data bits 6:2. It is accepted only if the frame just before it was 0x50 or 0x06. Any other frame in between disarms it. Bits 0, 1 and 7 are never loaded from the data.
- R6: Opcodes 0x05 and 0x35 shift the status byte out MSB first, changing MISO after SCK falling edges. The byte repeats every 8 clocks until chip-select rises. This works in both SPI modes and while BUSY is set.
- R7: Chip erase (0x60 or 0xC7) is ignored when the write-enable latch is clear or any protection bit is set.
- R8: A status write that is accepted clears the write-enable latch.
- R9: An accepted erase gives exactly one single-cycle erase_pulse and holds BUSY for ERASE_CYCLES system clocks. BUSY and the write-enable latch then both clear.
- R10: While BUSY is set, every opcode other than the two status reads is ignored.
- R11: The MISO output enable is high only while a status read is shifting data out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | Serial data into the device |
| spi_miso | output | 1 | Serial status data out |
| spi_miso_oe | output | 1 | Drive enable for MISO; low means high impedance |
| erase_pulse | output | 1 | One-cycle strobe telling the array to erase fully |

## Verification
The assertions check, on every cycle, that an erase strobe appears only when the latch was set, no protection bit was set and BUSY was clear. They also check that the strobe lasts one cycle, that the latch never rises during BUSY and is clear when BUSY falls, that protection bits change only after a chip-select rising edge, and that MISO is driven only inside a read. Only the bench scenarios can show which opcodes and frame lengths commit and which bit values they leave behind. They also show that arming is lost after an intervening frame, that read bytes repeat in both SPI modes, and how long BUSY lasts.

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl #(
  parameter int ERASE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  output logic erase_pulse
);
  localparam int CW = $clog2(ERASE_CYCLES + 1);
  localparam logic [7:0] OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_ARM = 8'h50,
                         OP_WRSR = 8'h01, OP_RD0 = 8'h05, OP_RD1 = 8'h35,
                         OP_ER0 = 8'h60, OP_ER1 = 8'hC7;

  logic [1:0] sck_sy, cs_sy, mosi_sy;
  logic sck_d, cs_d;
  wire sck_s  = sck_sy[1];
  wire cs_s   = cs_sy[1];
  wire mosi_s = mosi_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0; cs_sy <= '1; mosi_sy <= '0; sck_d <= 1'b0; cs_d <= 1'b1;
    end else begin
      sck_sy <= {sck_sy[0], spi_sck};
      cs_sy <= {cs_sy[0], spi_cs_n};
      mosi_sy <= {mosi_sy[0], spi_mosi};
      sck_d <= sck_s;
      cs_d <= cs_s;
    end

  wire sck_rise = sck_s & ~sck_d & ~cs_s;
  wire sck_fall = ~sck_s & sck_d & ~cs_s;
  wire cs_rise  = cs_s & ~cs_d;

  logic [15:0] shreg;
  logic [4:0]  bcnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg <= '0; bcnt <= '0;
    end else if (cs_s) begin
      bcnt <= '0;
    end else if (sck_rise) begin
      shreg <= {shreg[14:0], mosi_s};
      if (bcnt != 5'd31) bcnt <= bcnt + 5'd1;
    end

  logic busy, wel, aai, arm;
  logic [3:0] prot;
  logic [CW-1:0] ecnt;
  wire [7:0] status = {1'b0, aai, prot, wel, busy};

  wire is8 = (bcnt == 5'd8);
  wire is16 = (bcnt == 5'd16);
  wire [7:0] op8 = shreg[7:0];
  wire [7:0] op16 = shreg[15:8];
  wire [7:0] dat = shreg[7:0];
  wire cmd_ok = cs_rise & ~busy;

  wire do_wren  = cmd_ok & is8 & (op8 == OP_WREN);
  wire do_wrdi  = cmd_ok & is8 & (op8 == OP_WRDI);
  wire do_erase = cmd_ok & is8 & ((op8 == OP_ER0) | (op8 == OP_ER1)) & wel & (prot == 4'd0);
  wire do_wrsr  = cmd_ok & is16 & (op16 == OP_WRSR) & arm;
  wire erase_done = busy & (ecnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0; wel <= 1'b0; aai <= 1'b0; arm <= 1'b0;
      prot <= '0; ecnt <= '0; erase_pulse <= 1'b0;
    end else begin
      erase_pulse <= do_erase;
      if (cs_rise && bcnt != 5'd0)
        arm <= is8 & ~busy & ((op8 == OP_ARM) | (op8 == OP_WREN));
      if (do_erase) begin
        busy <= 1'b1;
        ecnt <= CW'(ERASE_CYCLES);
      end else if (busy) begin
        ecnt <= ecnt - CW'(1);
        if (erase_done) busy <= 1'b0;
      end
      if (erase_done || do_wrdi || do_wrsr) wel <= 1'b0;
      else if (do_wren) wel <= 1'b1;
      if (do_wrdi) aai <= 1'b0;
      else if (do_wrsr) aai <= dat[6];
      if (do_wrsr) prot <= dat[5:2];
    end

  logic rd_active, miso_q, oe_q;
  logic [2:0] bidx;
  logic [7:0] snap;
  wire [7:0] next_op = {shreg[6:0], mosi_s};
  wire rd_go = sck_rise & (bcnt == 5'd7) & ((next_op == OP_RD0) | (next_op == OP_RD1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_active <= 1'b0; miso_q <= 1'b0; oe_q <= 1'b0; bidx <= '0; snap <= '0;
    end else if (cs_s) begin
      rd_active <= 1'b0; oe_q <= 1'b0; bidx <= '0;
    end else begin
      if (rd_go) rd_active <= 1'b1;
      if (sck_fall && rd_active) begin
        oe_q <= 1'b1;
        bidx <= bidx + 3'd1;
        if (bidx == 3'd0) begin
          miso_q <= status[7];
          snap <= {status[6:0], 1'b0};
        end else begin
          miso_q <= snap[7];
          snap <= {snap[6:0], 1'b0};
        end
      end
    end

  assign spi_miso = miso_q;
  assign spi_miso_oe = oe_q;
endmodule

module spi_flash_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic erase_pulse,
  input logic busy,
  input logic wel,
  input logic [3:0] prot,
  input logic cs_rise,
  input logic miso_oe,
  input logic rd_active
);
  a_r7_erase_needs_rights: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |-> ($past(wel) && ($past(prot) == 4'd0) && !$past(busy)));
  a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse |=> !erase_pulse);
  a_r9_done_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);
  a_r10_no_enable_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !$rose(wel));
  a_r5_prot_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot) |-> $past(cs_rise));
  a_r11_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> rd_active);
endmodule

bind spi_flash_ctl spi_flash_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .erase_pulse(erase_pulse), .busy(busy), .wel(wel),
  .prot(prot), .cs_rise(cs_rise), .miso_oe(spi_miso_oe), .rd_active(rd_active)
);

// File: tb/spi_flash_ctl_bench.sv
module spi_flash_ctl_bench;
  localparam int HP = 8;
  localparam int ERASE = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, erase_pulse;

  int checks = 0, failures = 0, pulses = 0;
  logic [7:0] exp_q[$];
  logic [7:0] mon_sh = '0;
  int mon_cnt = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_flash_ctl #(.ERASE_CYCLES(ERASE)) u_spi_flash_ctl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .erase_pulse(erase_pulse));

  always @(posedge clk) if (rst_n && erase_pulse) pulses++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge spi_sck) if (mon_on) begin
    logic [7:0] b;
    b = {mon_sh[6:0], spi_miso};
    mon_sh = b;
    chk(spi_miso_oe === 1'b1, "R11 oe during read", int'(spi_miso_oe), 1);
    mon_cnt++;
    if (mon_cnt == 8) begin
      mon_cnt = 0;
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", b, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(b === e, "R6 status byte", b, e);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      spi_sck = 1'b0; spi_mosi = v[n-1-i]; wait_clk(HP);
      spi_sck = 1'b1; wait_clk(HP);
    end
  endtask

  task automatic frame(input logic [15:0] v, input int n, input bit m3);
    @(negedge clk); spi_sck = m3; wait_clk(2);
    spi_cs_n = 1'b0; wait_clk(HP);
    send_bits(v, n);
    if (!m3) spi_sck = 1'b0;
    wait_clk(HP); spi_cs_n = 1'b1; wait_clk(4 * HP);
  endtask

  task automatic rd(input logic [7:0] op, input int nb, input bit m3, input logic [7:0] e);
    for (int k = 0; k < nb; k++) exp_q.push_back(e);
    @(negedge clk); spi_sck = m3; wait_clk(2);
    spi_cs_n = 1'b0; wait_clk(HP);
    send_bits({8'h00, op}, 8);
    mon_on = 1'b1;
    send_bits(16'h0000, 8 * nb);
    mon_on = 1'b0;
    if (!m3) spi_sck = 1'b0;
    wait_clk(HP); spi_cs_n = 1'b1; wait_clk(4 * HP);
    chk(exp_q.size() == 0, "R6 all bytes seen", exp_q.size(), 0);
    chk(spi_miso_oe === 1'b0, "R11 oe idle after read", int'(spi_miso_oe), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    wait_clk(5); rst_n = 1'b1; wait_clk(5);
    chk(spi_miso_oe === 1'b0, "R1 oe at reset", int'(spi_miso_oe), 0);
    chk(pulses == 0, "R1 no strobe", pulses, 0);
    rd(8'h05, 1, 0, 8'h00);

    frame(16'h0006, 8, 0);
    rd(8'h05, 1, 0, 8'h02);                     // R2
    rd(8'h35, 1, 1, 8'h02);                     // R6 mode 3, second read opcode
    frame(16'h0004, 8, 1);
    rd(8'h05, 1, 0, 8'h00);                     // R4

    frame(16'h000C, 9, 0);                      // R3 nine-bit 0x06
    frame(16'h0003, 7, 0);                      // R3 seven-bit 0x06
    rd(8'h05, 1, 0, 8'h00);

    frame(16'h01FC, 16, 0);                     // R5 not armed (prior frame a read)
    rd(8'h05, 1, 0, 8'h00);
    frame(16'h0050, 8, 0);
    frame(16'h01FF, 16, 0);                     // R5 bits 6:2 only
    rd(8'h05, 1, 0, 8'h7C);
    frame(16'h0004, 8, 0);                      // R4 clears aai, keeps prot
    rd(8'h05, 1, 0, 8'h3C);

    frame(16'h0006, 8, 0);
    frame(16'h0060, 8, 0);                      // R7 protected
    chk(pulses == 0, "R7 refused when protected", pulses, 0);
    rd(8'h05, 1, 0, 8'h3E);

    frame(16'h0050, 8, 0);
    frame(16'h0100, 16, 0);
    rd(8'h05, 1, 0, 8'h00);
    frame(16'h0006, 8, 0);
    frame(16'h0104, 16, 0);                     // R8 armed by 0x06, latch cleared
    rd(8'h05, 1, 0, 8'h04);
    frame(16'h0050, 8, 0);
    frame(16'h0100, 16, 0);

    frame(16'h0050, 8, 0);
    rd(8'h05, 1, 0, 8'h00);
    frame(16'h013C, 16, 0);                     // R5 disarmed by intervening read
    rd(8'h05, 1, 0, 8'h00);

    frame(16'h00C7, 8, 0);                      // R7 latch clear
    chk(pulses == 0, "R7 refused without latch", pulses, 0);

    frame(16'h0006, 8, 1);
    frame(16'h00C7, 8, 1);                      // R9 accepted
    chk(pulses == 1, "R9 one strobe", pulses, 1);
    rd(8'h05, 3, 0, 8'h03);                     // R6 repeats, readable while busy
    frame(16'h0004, 8, 0);                      // R10 ignored while busy
    frame(16'h0050, 8, 0);
    frame(16'h013C, 16, 0);                     // R10 status write ignored
    rd(8'h35, 1, 1, 8'h03);
    wait_clk(ERASE + 100);
    rd(8'h05, 1, 0, 8'h00);                     // R9 busy and latch clear
    chk(pulses == 1, "R9 still one strobe", pulses, 1);

    frame(16'h0006, 8, 0);
    frame(16'h0060, 8, 0);
    chk(pulses == 2, "R9 second opcode strobe", pulses, 2);
    wait_clk(ERASE + 100);
    rd(8'h05, 1, 1, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule